// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative translation buffer. Each slot maps one virtual page to one physical page. Alongside the page numbers, a slot stores an address-space number, a global flag and an attribute word. The attribute word holds a read-enable mask and a write-enable mask, each with one bit per privilege mode, plus two fault-on-access flags. The lookup path is combinational. It compares the presented virtual page and current address-space number against every slot and returns the hit flag, the slot index and the stored fields of the winning slot.

A refill agent, which is outside this block, writes new mappings through the insert port. The slot written is always the one under the round-robin next-to-use pointer. A read port shows the slot at that pointer, so the refill agent can inspect or skip the victim before it writes. One command input selects one of three invalidations: every slot, every non-global slot, or the slots that match one virtual page in the given address space.

Top module: `tlb_asn`

## Requirements
- R1: A lookup hits only on a valid slot whose tag equals `lk_vpn` and which is global or holds an address-space number equal to `lk_asn`. On a hit, `lk_ppn`, `lk_global` and `lk_attr` return the fields stored in that slot. On a miss, `lk_hit` is 0.
- R2: When several slots match a lookup, the slot with the lowest index wins, and `lk_idx` reports that index.
- R3: An accepted insert writes the slot at the next-to-use pointer, overwriting any valid slot there. It marks the slot valid, stores the page number as the tag, and advances the pointer by one on the same clock edge.
- R4: The next-to-use pointer wraps from slot ENTRIES-1 back to slot 0.
- R5: `flush_cmd` = 1 (all) clears every valid bit and sets the pointer to 0.
- R6: `flush_cmd` = 2 (non-global) invalidates every slot whose global bit is clear. Global slots stay valid and unchanged, and the pointer does not move.
- R7: `flush_cmd` = 3 (single page) invalidates every valid slot whose tag equals `flush_vpn` and which is global or whose address-space number equals `flush_asn`. All other slots are untouched.
- R8: `rd_ptr`, `rd_valid`, `rd_vpn`, `rd_ppn`, `rd_asn`, `rd_global` and `rd_attr` show the slot at the pointer. In a cycle with no insert, the pointer advances only when `rd_advance` is 1. An insert and `rd_advance` in the same cycle advance the pointer by one.
- R9: In a cycle where `flush_cmd` is nonzero, an insert is ignored. Only the flush acts, and the ignored insert does not advance the pointer.
- R10: After a synchronous active-low reset, every slot is invalid and the pointer is 0.
- R11: The attribute word is laid out as follows: bits [MODES-1:0] are the per-mode read enables, bits [2*MODES-1:MODES] are the per-mode write enables, bit 2*MODES is fault-on-read and bit 2*MODES+1 is fault-on-write. The block stores and returns this word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | clog2(ENTRIES) | Index of the winning slot |
| lk_ppn | output | PPN_W | Physical page of the winning slot |
| lk_global | output | 1 | Global flag of the winning slot |
| lk_attr | output | 2*MODES+2 | Attribute word of the winning slot |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Insert virtual page (stored as tag) |
| ins_ppn | input | PPN_W | Insert physical page |
| ins_asn | input | ASN_W | Insert address-space number |
| ins_global | input | 1 | Insert global flag |
| ins_attr | input | 2*MODES+2 | Insert attribute word |
| flush_cmd | input | 2 | 0 none, 1 all, 2 non-global, 3 single page |
| flush_vpn | input | VPN_W | Page for single-page flush |
| flush_asn | input | ASN_W | Address space for single-page flush |
| rd_advance | input | 1 | Advance the next-to-use pointer |
| rd_ptr | output | clog2(ENTRIES) | Next-to-use pointer |
| rd_valid | output | 1 | Valid bit of the slot at the pointer |
| rd_vpn | output | VPN_W | Tag of the slot at the pointer |
| rd_ppn | output | PPN_W | Physical page of the slot at the pointer |
| rd_asn | output | ASN_W | Address-space number of the slot at the pointer |
| rd_global | output | 1 | Global flag of the slot at the pointer |
| rd_attr | output | 2*MODES+2 | Attribute word of the slot at the pointer |

## Verification
The hardest situation to reach is a lookup that matches more than one slot: one slot through its address-space number and another through its global bit, with the same page number. Inserts cannot choose their slot, so the stimulus places entries only through the round-robin order. It inserts a global duplicate of an already present page, then looks that page up under two different address spaces to check that the lower slot wins. The single-page flush is then aimed at that same page. The expected result is that it removes both the address-space match and the global match but spares a third copy held under another address space.

// File: rtl/tlb_asn_pkg.sv
// Package: shared command encoding for the translation buffer.
// Assumes: the flush command is a 2-bit field decoded by the top module.
package tlb_asn_pkg;

    typedef enum logic [1:0] {
        FL_NONE   = 2'd0,
        FL_ALL    = 2'd1,
        FL_LOCAL  = 2'd2,
        FL_PAGE   = 2'd3
    } flush_e;

    // Width of the attribute word for a given mode count.
    function automatic int attr_width(input int modes);
        return 2 * modes + 2;
    endfunction

endpackage

// File: rtl/tlb_match.sv
// Module: per-slot comparator bank.
// Compares one virtual page and address space against every slot at once.
// A slot matches when it is valid, its tag is equal, and it is global or
// its address-space number is equal.
// Assumes: all inputs are stable within the cycle; purely combinational.
module tlb_match #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 28,
    parameter int ASN_W   = 8
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] glb_i,
    input  logic [VPN_W-1:0]   tag_i [ENTRIES],
    input  logic [ASN_W-1:0]   asn_i [ENTRIES],
    input  logic [VPN_W-1:0]   key_vpn_i,
    input  logic [ASN_W-1:0]   key_asn_i,
    output logic [ENTRIES-1:0] match_o
);

    // One comparator per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_o[g] = valid_i[g]
                          && (tag_i[g] == key_vpn_i)
                          && (glb_i[g] || (asn_i[g] == key_asn_i));
    end

endmodule

// File: rtl/tlb_first_set.sv
// Module: lowest-index priority encoder.
// Reports whether any bit is set and the index of the lowest set bit.
// Assumes: N >= 2; combinational.
module tlb_first_set #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_nlu_ptr.sv
// Module: round-robin next-to-use pointer.
// Clears to zero on reset or on clear_i, steps by one on step_i, and wraps
// from the last slot to slot 0.
// Assumes: clear_i has priority over step_i.
module tlb_nlu_ptr #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] ptr_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;

    // Pointer register: clear, else step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr_q <= '0;
        else if (clear_i)  ptr_q <= '0;
        else if (step_i)   ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    assign ptr_o = ptr_q;

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && step_i && ptr_q == LAST) |=> (ptr_q == '0));

    // R5
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (ptr_q == '0));

endmodule

// File: rtl/tlb_asn.sv
// Module: address-space-tagged fully associative translation buffer (top).
// Holds ENTRIES mappings. Provides a combinational lookup with
// lowest-index priority, a round-robin insert, three flush commands and a
// read port at the next-to-use pointer.
// Assumes: a flush in the same cycle as an insert wins and drops the insert.
module tlb_asn
    import tlb_asn_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 28,
    parameter int PPN_W   = 28,
    parameter int ASN_W   = 8,
    parameter int MODES   = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int ATTR_W = attr_width(MODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              lk_global,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              ins_valid,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [ASN_W-1:0]  ins_asn,
    input  logic              ins_global,
    input  logic [ATTR_W-1:0] ins_attr,
    input  logic [1:0]        flush_cmd,
    input  logic [VPN_W-1:0]  flush_vpn,
    input  logic [ASN_W-1:0]  flush_asn,
    input  logic              rd_advance,
    output logic [IDX_W-1:0]  rd_ptr,
    output logic              rd_valid,
    output logic [VPN_W-1:0]  rd_vpn,
    output logic [PPN_W-1:0]  rd_ppn,
    output logic [ASN_W-1:0]  rd_asn,
    output logic              rd_global,
    output logic [ATTR_W-1:0] rd_attr
);

    // Slot storage.
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] glb_q;
    logic [VPN_W-1:0]   tag_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    logic [ASN_W-1:0]   asn_q  [ENTRIES];
    logic [ATTR_W-1:0]  attr_q [ENTRIES];

    flush_e             fcmd;
    logic               ins_go;
    logic               ptr_clear;
    logic               ptr_step;
    logic [IDX_W-1:0]   ptr;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;
    logic               lk_found;
    logic [IDX_W-1:0]   lk_sel;

    // Command decode: any flush blocks the insert.
    always_comb begin
        fcmd      = flush_e'(flush_cmd);
        ins_go    = ins_valid && (fcmd == FL_NONE);
        ptr_clear = (fcmd == FL_ALL);
        ptr_step  = ins_go || rd_advance;
    end

    // Comparator bank for lookups.
    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
        .valid_i   (valid_q),
        .glb_i     (glb_q),
        .tag_i     (tag_q),
        .asn_i     (asn_q),
        .key_vpn_i (lk_vpn),
        .key_asn_i (lk_asn),
        .match_o   (lk_match)
    );

    // Comparator bank for single-page flushes.
    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
        .valid_i   (valid_q),
        .glb_i     (glb_q),
        .tag_i     (tag_q),
        .asn_i     (asn_q),
        .key_vpn_i (flush_vpn),
        .key_asn_i (flush_asn),
        .match_o   (fl_match)
    );

    // Lowest matching slot wins.
    tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .vec_i   (lk_match),
        .found_o (lk_found),
        .idx_o   (lk_sel)
    );

    // Replacement pointer.
    tlb_nlu_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (ptr_clear),
        .step_i  (ptr_step),
        .ptr_o   (ptr)
    );

    // Valid bits: reset, flush variants, or set on insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            unique case (fcmd)
                FL_ALL:   valid_q <= '0;
                FL_LOCAL: valid_q <= valid_q & glb_q;
                FL_PAGE:  valid_q <= valid_q & ~fl_match;
                default:  if (ins_go) valid_q[ptr] <= 1'b1;
            endcase
        end
    end

    // Slot payload: written on an accepted insert only.
    always_ff @(posedge clk) begin
        if (ins_go) begin
            tag_q[ptr]  <= ins_vpn;
            ppn_q[ptr]  <= ins_ppn;
            asn_q[ptr]  <= ins_asn;
            glb_q[ptr]  <= ins_global;
            attr_q[ptr] <= ins_attr;
        end
    end

    // Lookup result fields, zero on a miss.
    always_comb begin
        lk_hit    = lk_found;
        lk_idx    = lk_sel;
        lk_ppn    = lk_found ? ppn_q[lk_sel]  : '0;
        lk_global = lk_found ? glb_q[lk_sel]  : 1'b0;
        lk_attr   = lk_found ? attr_q[lk_sel] : '0;
    end

    // Read port at the next-to-use pointer.
    always_comb begin
        rd_ptr    = ptr;
        rd_valid  = valid_q[ptr];
        rd_vpn    = tag_q[ptr];
        rd_ppn    = ppn_q[ptr];
        rd_asn    = asn_q[ptr];
        rd_global = glb_q[ptr];
        rd_attr   = attr_q[ptr];
    end

    // R1
    lookup_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid_q[lk_idx] && tag_q[lk_idx] == lk_vpn
                    && (glb_q[lk_idx] || asn_q[lk_idx] == lk_asn)));

    // R2
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ((lk_match & ~({ENTRIES{1'b1}} << lk_idx)) == '0));

    // R3
    insert_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && flush_cmd == 2'd0)
        |=> (valid_q[$past(ptr)] && tag_q[$past(ptr)] == $past(ins_vpn)
             && ptr != $past(ptr)));

    // R5
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_cmd == 2'd1) |=> (valid_q == '0));

    // R6
    keep_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_cmd == 2'd2)
        |=> ((valid_q & ~glb_q) == '0 && (valid_q & glb_q) == $past(valid_q & glb_q)));

    // R7
    flush_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_cmd == 2'd3) |=> ((valid_q & $past(fl_match)) == '0));

    // R8
    idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_valid && !rd_advance && flush_cmd != 2'd1) |=> (ptr == $past(ptr)));

    // R9
    flush_blocks_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !rd_advance && (flush_cmd == 2'd2 || flush_cmd == 2'd3))
        |=> (ptr == $past(ptr)));

endmodule

// File: tb/tlb_asn_bench.sv
// Bench: vector table walked by one loop, then directed reset and corner tests.
module tlb_asn_bench;

    localparam int ENT   = 8;
    localparam int VW    = 28;
    localparam int PW    = 28;
    localparam int AW    = 8;
    localparam int MD    = 4;
    localparam int IW    = 3;
    localparam int ATW   = 2 * MD + 2;

    localparam logic [2:0] OP_INS  = 3'd0;
    localparam logic [2:0] OP_LOOK = 3'd1;
    localparam logic [2:0] OP_FALL = 3'd2;
    localparam logic [2:0] OP_FLOC = 3'd3;
    localparam logic [2:0] OP_FPG  = 3'd4;

    typedef struct packed {
        logic [2:0]    op;
        logic [VW-1:0] vpn;
        logic [AW-1:0] asn;
        logic          glb;
        logic [PW-1:0] ppn;
        logic          hit;
        logic [IW-1:0] idx;
        logic [IW-1:0] ptr;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{OP_INS,  28'h100, 8'd1, 1'b0, 28'hA00, 1'b0, 3'd0, 3'd1, 4'd3},  // R3
        '{OP_INS,  28'h200, 8'd2, 1'b1, 28'hB00, 1'b0, 3'd0, 3'd2, 4'd3},  // R3
        '{OP_INS,  28'h100, 8'd3, 1'b0, 28'hC00, 1'b0, 3'd0, 3'd3, 4'd3},  // R3
        '{OP_LOOK, 28'h100, 8'd1, 1'b0, 28'hA00, 1'b1, 3'd0, 3'd3, 4'd1},  // R1
        '{OP_LOOK, 28'h100, 8'd3, 1'b0, 28'hC00, 1'b1, 3'd2, 3'd3, 4'd1},  // R1
        '{OP_LOOK, 28'h100, 8'd5, 1'b0, 28'h000, 1'b0, 3'd0, 3'd3, 4'd1},  // R1
        '{OP_LOOK, 28'h200, 8'd9, 1'b0, 28'hB00, 1'b1, 3'd1, 3'd3, 4'd1},  // R1
        '{OP_INS,  28'h100, 8'd7, 1'b1, 28'hD00, 1'b0, 3'd0, 3'd4, 4'd3},  // R3
        '{OP_LOOK, 28'h100, 8'd3, 1'b0, 28'hC00, 1'b1, 3'd2, 3'd4, 4'd2},  // R2
        '{OP_LOOK, 28'h100, 8'd1, 1'b0, 28'hA00, 1'b1, 3'd0, 3'd4, 4'd2},  // R2
        '{OP_FPG,  28'h100, 8'd1, 1'b0, 28'h000, 1'b0, 3'd0, 3'd4, 4'd7},  // R7
        '{OP_LOOK, 28'h100, 8'd1, 1'b0, 28'h000, 1'b0, 3'd0, 3'd4, 4'd7},  // R7
        '{OP_LOOK, 28'h100, 8'd3, 1'b0, 28'hC00, 1'b1, 3'd2, 3'd4, 4'd7},  // R7
        '{OP_FLOC, 28'h000, 8'd0, 1'b0, 28'h000, 1'b0, 3'd0, 3'd4, 4'd6},  // R6
        '{OP_LOOK, 28'h100, 8'd3, 1'b0, 28'h000, 1'b0, 3'd0, 3'd4, 4'd6},  // R6
        '{OP_LOOK, 28'h200, 8'd4, 1'b0, 28'hB00, 1'b1, 3'd1, 3'd4, 4'd6},  // R6
        '{OP_FALL, 28'h000, 8'd0, 1'b0, 28'h000, 1'b0, 3'd0, 3'd0, 4'd5},  // R5
        '{OP_LOOK, 28'h200, 8'd4, 1'b0, 28'h000, 1'b0, 3'd0, 3'd0, 4'd5}   // R5
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [VW-1:0]  lk_vpn = '0;
    logic [AW-1:0]  lk_asn = '0;
    logic           lk_hit;
    logic [IW-1:0]  lk_idx;
    logic [PW-1:0]  lk_ppn;
    logic           lk_global;
    logic [ATW-1:0] lk_attr;
    logic           ins_valid = 1'b0;
    logic [VW-1:0]  ins_vpn = '0;
    logic [PW-1:0]  ins_ppn = '0;
    logic [AW-1:0]  ins_asn = '0;
    logic           ins_global = 1'b0;
    logic [ATW-1:0] ins_attr = '0;
    logic [1:0]     flush_cmd = 2'd0;
    logic [VW-1:0]  flush_vpn = '0;
    logic [AW-1:0]  flush_asn = '0;
    logic           rd_advance = 1'b0;
    logic [IW-1:0]  rd_ptr;
    logic           rd_valid;
    logic [VW-1:0]  rd_vpn;
    logic [PW-1:0]  rd_ppn;
    logic [AW-1:0]  rd_asn;
    logic           rd_global;
    logic [ATW-1:0] rd_attr;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tlb_asn #(.ENTRIES(ENT), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW), .MODES(MD)) u_tlb_asn (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_ppn(lk_ppn), .lk_global(lk_global), .lk_attr(lk_attr),
        .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
        .ins_asn(ins_asn), .ins_global(ins_global), .ins_attr(ins_attr),
        .flush_cmd(flush_cmd), .flush_vpn(flush_vpn), .flush_asn(flush_asn),
        .rd_advance(rd_advance), .rd_ptr(rd_ptr), .rd_valid(rd_valid),
        .rd_vpn(rd_vpn), .rd_ppn(rd_ppn), .rd_asn(rd_asn),
        .rd_global(rd_global), .rd_attr(rd_attr)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ins_valid  = 1'b0;
        flush_cmd  = 2'd0;
        rd_advance = 1'b0;
    endtask

    // One clocked action; checks after the edge happen at edge + 1 ns.
    task automatic tick();
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic do_insert(input logic [VW-1:0] v, input logic [AW-1:0] a,
                             input logic g, input logic [PW-1:0] p,
                             input logic [ATW-1:0] at);
        @(negedge clk);
        ins_valid = 1'b1; ins_vpn = v; ins_asn = a; ins_global = g;
        ins_ppn = p; ins_attr = at;
        tick();
    endtask

    task automatic look(input logic [VW-1:0] v, input logic [AW-1:0] a);
        @(negedge clk);
        lk_vpn = v; lk_asn = a;
        #2;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog R1..: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R10", "rd_ptr",   64'(rd_ptr),   64'd0);
        chk("R10", "rd_valid", 64'(rd_valid), 64'd0);
        chk("R10", "lk_hit",   64'(lk_hit),   64'd0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VT[i].req);
            @(negedge clk);
            lk_vpn = VT[i].vpn; lk_asn = VT[i].asn;
            flush_vpn = VT[i].vpn; flush_asn = VT[i].asn;
            case (VT[i].op)
                OP_INS: begin
                    ins_valid = 1'b1; ins_vpn = VT[i].vpn; ins_asn = VT[i].asn;
                    ins_global = VT[i].glb; ins_ppn = VT[i].ppn;
                    ins_attr = ATW'(VT[i].ppn >> 8);
                end
                OP_FALL: flush_cmd = 2'd1;
                OP_FLOC: flush_cmd = 2'd2;
                OP_FPG:  flush_cmd = 2'd3;
                default: ;
            endcase
            #2;
            if (VT[i].op == OP_LOOK) begin
                chk(rq, "lk_hit", 64'(lk_hit), 64'(VT[i].hit));
                if (VT[i].hit) begin
                    chk(rq, "lk_idx", 64'(lk_idx), 64'(VT[i].idx));
                    chk(rq, "lk_ppn", 64'(lk_ppn), 64'(VT[i].ppn));
                end
            end
            tick();
            chk(rq, "rd_ptr", 64'(rd_ptr), 64'(VT[i].ptr));
        end

        // R11/R1: attribute word and global flag returned unchanged
        do_insert(28'h777, 8'd9, 1'b1, 28'h1234, 10'h2A5);
        look(28'h777, 8'd3);
        chk("R11", "lk_attr",   64'(lk_attr),   64'h2A5);
        chk("R1",  "lk_global", 64'(lk_global), 64'd1);
        @(negedge clk); flush_cmd = 2'd1; tick();

        // R4: eight inserts wrap the pointer back to 0
        for (int k = 0; k < ENT; k++) begin
            do_insert(VW'(28'h10 + k), 8'd1, 1'b0, PW'(28'h900 + k), '0);
            chk("R4", "rd_ptr", 64'(rd_ptr), 64'((k + 1) % ENT));
        end
        // R3: next insert overwrites slot 0
        do_insert(28'h50, 8'd1, 1'b0, 28'h950, '0);
        look(28'h10, 8'd1);
        chk("R3", "old slot0 hit", 64'(lk_hit), 64'd0);
        look(28'h50, 8'd1);
        chk("R3", "new slot0 hit", 64'(lk_hit), 64'd1);
        chk("R3", "new slot0 idx", 64'(lk_idx), 64'd0);

        // R8: read port shows slot 1, holds when idle, moves on rd_advance
        chk("R8", "rd_vpn", 64'(rd_vpn), 64'h11);
        chk("R8", "rd_valid", 64'(rd_valid), 64'd1);
        @(negedge clk); tick();
        chk("R8", "rd_ptr idle", 64'(rd_ptr), 64'd1);
        @(negedge clk); rd_advance = 1'b1; tick();
        chk("R8", "rd_ptr adv", 64'(rd_ptr), 64'd2);
        chk("R8", "rd_ppn", 64'(rd_ppn), 64'h902);
        chk("R8", "rd_asn", 64'(rd_asn), 64'd1);

        // R9: insert with a non-global flush is dropped
        @(negedge clk);
        ins_valid = 1'b1; ins_vpn = 28'h66; ins_asn = 8'd2; ins_global = 1'b1;
        ins_ppn = 28'h666; flush_cmd = 2'd2;
        tick();
        chk("R9", "rd_ptr", 64'(rd_ptr), 64'd2);
        look(28'h66, 8'd2);
        chk("R9", "dropped insert hit", 64'(lk_hit), 64'd0);
        look(28'h12, 8'd1);
        chk("R9", "local flush applied", 64'(lk_hit), 64'd0);

        // R5/R9: flush-all with insert resets pointer, nothing inserted
        do_insert(28'h70, 8'd0, 1'b1, 28'h700, '0);
        @(negedge clk);
        ins_valid = 1'b1; ins_vpn = 28'h71; ins_global = 1'b1; flush_cmd = 2'd1;
        tick();
        chk("R5", "rd_ptr", 64'(rd_ptr), 64'd0);
        look(28'h71, 8'd0);
        chk("R9", "insert under flush-all", 64'(lk_hit), 64'd0);
        look(28'h70, 8'd0);
        chk("R5", "global cleared", 64'(lk_hit), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule